// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small processor that finishes one instruction on every clock edge. It handles a 32-bit load/store instruction subset: register-register and register-immediate arithmetic, logic and shifts, signed and unsigned 32x32 multiplication into a high/low result pair, word loads and stores, jumps, calls, register-indirect jumps and three conditional branches. Instructions come from an external combinational read port that is addressed by the word index of the program counter. Data lives in a 64-word memory inside the block.

Before a run, the host writes the data memory through a load port and then pulses `start`. The core then fetches, decodes, executes and writes back one instruction per cycle. It stops when the program counter becomes zero. This happens either because the program jumps there on purpose or because it meets an instruction it does not know. At that point `done` rises and `inst_count` holds the number of instructions executed. The host reads the results back through a combinational debug read port on the data memory.

Top module: `scpu_core`

## Requirements
- R1: After reset, `pc_out` is 0x00400000, `done` is 0 and `inst_count` is 0. Register 29 holds 0x7fffeffc and every other register holds 0. The PC holds its reset value until `start`.
- R2: Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6], funct [5:0], immediate [15:0] and jump target [25:0]. `imem_addr` is PC bits 7:2. Each instruction that does not redirect the PC advances it by 4.
- R3: Opcode 0 with funct 33 gives rd=rs+rt, funct 35 gives rd=rs-rt, funct 36 gives AND, 37 gives OR and 38 gives XOR. Funct 0 shifts rt left by shamt and funct 2 shifts it right logically by shamt. Funct 4 and 6 do the same shifts by rs[4:0]. Funct 42 is a signed less-than and funct 43 is an unsigned less-than, each giving 1 or 0.
- R4: The immediate forms write rt. Opcode 9 adds the sign-extended immediate. Opcodes 12, 13 and 14 apply AND, OR and XOR with the zero-extended immediate. Opcode 15 loads immediate<<16. Opcode 10 compares signed against the sign-extended immediate. Opcode 11 compares unsigned against the zero-extended immediate.
- R5: Funct 24 (signed) and funct 25 (unsigned) multiply rs by rt and hold the 64-bit product as a high word and a low word. Funct 16 copies the high word to rd and funct 18 copies the low word to rd.
- R6: Opcode 35 loads and opcode 43 stores a word at rs plus the sign-extended immediate. The word index is address bits 7:2. A store takes effect at the clock edge that executes it.
- R7: Opcode 2 jumps and opcode 3 calls, each setting the PC to {4'b0, target, 2'b00}. A call first writes its own address plus 4 into register 31. Opcode 0 with funct 8 sets the PC to rs.
- R8: Opcode 4 branches when rs==rt, opcode 5 when rs!=rt, and opcode 1 when rs is non-negative as a signed value (rt is ignored). A taken branch sets the PC to the branch's own address plus the sign-extended immediate shifted left by 2.
- R9: Register 0 reads as zero even after an instruction writes it.
- R10: Any opcode, or opcode-0 funct, not listed here sets the PC to 0.
- R11: When the PC becomes 0, `done` rises and stays high. No further instruction executes until reset.
- R12: `inst_count` rises by one for every executed instruction, including the one that ends the run.
- R13: While the core is not running, `load_en` writes `load_data` into data word `load_addr`. `dbg_data` shows data word `dbg_addr` combinationally. `start` begins execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins execution from the reset PC |
| imem_addr | output | 6 | Instruction word index (PC bits 7:2) |
| imem_data | input | 32 | Instruction word at `imem_addr`, combinational |
| load_en | input | 1 | Data memory preload write enable |
| load_addr | input | 6 | Preload word index |
| load_data | input | 32 | Preload data |
| dbg_addr | input | 6 | Debug read word index |
| dbg_data | output | 32 | Data memory word at `dbg_addr` |
| done | output | 1 | High once the PC has reached zero |
| inst_count | output | 32 | Executed-instruction count |
| pc_out | output | 32 | Current program counter |

## Verification
A `start` pulse is captured at the next rising edge. Every rising edge after that retires exactly one instruction, and its register write, store, PC update and count increment all land at that same edge. The halting instruction raises `done` at its own edge. The bench therefore drives inputs and samples outputs only on falling edges. It polls `done` once per cycle and reads memory through the combinational debug port only after `done` is seen. It compares the final memory and the count with an instruction-level bench model of the same program.

// File: rtl/scpu_pkg.sv
`timescale 1ns/1ps
package scpu_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2
  } run_state_t;

  // primary opcodes
  localparam logic [5:0] OPC_ALUR  = 6'd0;
  localparam logic [5:0] OPC_BGEZ  = 6'd1;
  localparam logic [5:0] OPC_JUMP  = 6'd2;
  localparam logic [5:0] OPC_CALL  = 6'd3;
  localparam logic [5:0] OPC_BEQ   = 6'd4;
  localparam logic [5:0] OPC_BNE   = 6'd5;
  localparam logic [5:0] OPC_ADDI  = 6'd9;
  localparam logic [5:0] OPC_SLTI  = 6'd10;
  localparam logic [5:0] OPC_SLTIU = 6'd11;
  localparam logic [5:0] OPC_ANDI  = 6'd12;
  localparam logic [5:0] OPC_ORI   = 6'd13;
  localparam logic [5:0] OPC_XORI  = 6'd14;
  localparam logic [5:0] OPC_LUI   = 6'd15;
  localparam logic [5:0] OPC_LOAD  = 6'd35;
  localparam logic [5:0] OPC_STORE = 6'd43;

  // function codes for the register form
  localparam logic [5:0] FN_SLL   = 6'd0;
  localparam logic [5:0] FN_SRL   = 6'd2;
  localparam logic [5:0] FN_SLLV  = 6'd4;
  localparam logic [5:0] FN_SRLV  = 6'd6;
  localparam logic [5:0] FN_JREG  = 6'd8;
  localparam logic [5:0] FN_MFHI  = 6'd16;
  localparam logic [5:0] FN_MFLO  = 6'd18;
  localparam logic [5:0] FN_MULS  = 6'd24;
  localparam logic [5:0] FN_MULU  = 6'd25;
  localparam logic [5:0] FN_ADD   = 6'd33;
  localparam logic [5:0] FN_SUB   = 6'd35;
  localparam logic [5:0] FN_AND   = 6'd36;
  localparam logic [5:0] FN_OR    = 6'd37;
  localparam logic [5:0] FN_XOR   = 6'd38;
  localparam logic [5:0] FN_SLT   = 6'd42;
  localparam logic [5:0] FN_SLTU  = 6'd43;

  function automatic logic [31:0] f_sext16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] f_zext16(input logic [15:0] v);
    return {16'b0, v};
  endfunction

  function automatic logic [31:0] f_lt_s(input logic [31:0] a, input logic [31:0] b);
    return {31'b0, ($signed(a) < $signed(b))};
  endfunction

  function automatic logic [31:0] f_lt_u(input logic [31:0] a, input logic [31:0] b);
    return {31'b0, (a < b)};
  endfunction

  function automatic logic [63:0] f_mul_s(input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] x;
    logic signed [63:0] y;
    x = $signed({{32{a[31]}}, a});
    y = $signed({{32{b[31]}}, b});
    return x * y;
  endfunction

  function automatic logic [63:0] f_mul_u(input logic [31:0] a, input logic [31:0] b);
    return {32'b0, a} * {32'b0, b};
  endfunction

  // taken branch: relative to the branch's own address
  function automatic logic [31:0] f_branch_tgt(input logic [31:0] pc, input logic [15:0] imm);
    return pc + {{14{imm[15]}}, imm, 2'b00};
  endfunction

  function automatic logic [31:0] f_jump_tgt(input logic [25:0] t);
    return {4'b0000, t, 2'b00};
  endfunction
endpackage

// File: rtl/scpu_regfile.sv
`timescale 1ns/1ps
module scpu_regfile import scpu_pkg::*; #(
  parameter int          DEPTH   = 32,
  parameter int          SP_IDX  = 29,
  parameter logic [31:0] SP_INIT = 32'h7fffeffc,
  localparam int         AW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_idx,
  output logic [31:0]   ra_val,
  input  logic [AW-1:0] rb_idx,
  output logic [31:0]   rb_val,
  input  logic          we,
  input  logic [AW-1:0] w_idx,
  input  logic [31:0]   w_val
);
  logic [31:0] regs [DEPTH];

  // entry 0 is cleared at reset and never written afterwards
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= (i == SP_IDX) ? SP_INIT : '0;
    end else if (we && (w_idx != '0)) begin
      regs[w_idx] <= w_val;
    end
  end

  assign ra_val = regs[ra_idx];
  assign rb_val = regs[rb_idx];
endmodule

// File: rtl/scpu_dmem.sv
`timescale 1ns/1ps
module scpu_dmem #(
  parameter int  WORDS = 64,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata,
  input  logic [AW-1:0] dbg_addr,
  output logic [31:0]   dbg_data
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata    = mem[raddr];
  assign dbg_data = mem[dbg_addr];

  // R6 / R13: a write lands in the addressed word at the edge it is issued
  a_r6_store_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/scpu_exec.sv
`timescale 1ns/1ps
module scpu_exec import scpu_pkg::*; (
  input  logic [5:0]  op,
  input  logic [5:0]  fn,
  input  logic [4:0]  shamt,
  input  logic [15:0] imm,
  input  logic [31:0] a,
  input  logic [31:0] b,
  input  logic [31:0] hi,
  input  logic [31:0] lo,
  output logic [31:0] res,
  output logic        wr_en,
  output logic        wr_rd,
  output logic        hilo_we,
  output logic [63:0] hilo_new,
  output logic        ld,
  output logic        st,
  output logic        jmp,
  output logic        lnk,
  output logic        jreg,
  output logic        br,
  output logic        cond,
  output logic        ill
);
  always_comb begin
    res      = '0;
    wr_en    = 1'b0;
    wr_rd    = 1'b0;
    hilo_we  = 1'b0;
    hilo_new = '0;
    ld       = 1'b0;
    st       = 1'b0;
    jmp      = 1'b0;
    lnk      = 1'b0;
    jreg     = 1'b0;
    br       = 1'b0;
    cond     = 1'b0;
    ill      = 1'b0;
    case (op)
      OPC_ALUR: begin
        wr_rd = 1'b1;
        wr_en = 1'b1;
        case (fn)
          FN_ADD:  res = a + b;
          FN_SUB:  res = a - b;
          FN_AND:  res = a & b;
          FN_OR:   res = a | b;
          FN_XOR:  res = a ^ b;
          FN_SLL:  res = b << shamt;
          FN_SRL:  res = b >> shamt;
          FN_SLLV: res = b << a[4:0];
          FN_SRLV: res = b >> a[4:0];
          FN_SLT:  res = f_lt_s(a, b);
          FN_SLTU: res = f_lt_u(a, b);
          FN_MFHI: res = hi;
          FN_MFLO: res = lo;
          FN_MULS: begin wr_en = 1'b0; hilo_we = 1'b1; hilo_new = f_mul_s(a, b); end
          FN_MULU: begin wr_en = 1'b0; hilo_we = 1'b1; hilo_new = f_mul_u(a, b); end
          FN_JREG: begin wr_en = 1'b0; jreg = 1'b1; end
          default: begin wr_en = 1'b0; ill = 1'b1; end
        endcase
      end
      OPC_JUMP:  jmp = 1'b1;
      OPC_CALL:  begin jmp = 1'b1; lnk = 1'b1; end
      OPC_ADDI:  begin wr_en = 1'b1; res = a + f_sext16(imm); end
      OPC_SLTI:  begin wr_en = 1'b1; res = f_lt_s(a, f_sext16(imm)); end
      OPC_SLTIU: begin wr_en = 1'b1; res = f_lt_u(a, f_zext16(imm)); end
      OPC_ANDI:  begin wr_en = 1'b1; res = a & f_zext16(imm); end
      OPC_ORI:   begin wr_en = 1'b1; res = a | f_zext16(imm); end
      OPC_XORI:  begin wr_en = 1'b1; res = a ^ f_zext16(imm); end
      OPC_LUI:   begin wr_en = 1'b1; res = {imm, 16'b0}; end
      OPC_LOAD:  begin wr_en = 1'b1; ld = 1'b1; end
      OPC_STORE: st = 1'b1;
      OPC_BEQ:   begin br = 1'b1; cond = (a == b); end
      OPC_BNE:   begin br = 1'b1; cond = (a != b); end
      OPC_BGEZ:  begin br = 1'b1; cond = ~a[31]; end
      default:   ill = 1'b1;
    endcase
  end
endmodule

// File: rtl/scpu_core.sv
`timescale 1ns/1ps
module scpu_core import scpu_pkg::*; #(
  parameter int          IM_WORDS = 64,
  parameter int          DM_WORDS = 64,
  parameter int          RF_DEPTH = 32,
  parameter int          CNT_W    = 32,
  parameter logic [31:0] RESET_PC = 32'h00400000,
  parameter logic [31:0] SP_INIT  = 32'h7fffeffc,
  localparam int         IM_AW    = $clog2(IM_WORDS),
  localparam int         DM_AW    = $clog2(DM_WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic [IM_AW-1:0] imem_addr,
  input  logic [31:0]      imem_data,
  input  logic             load_en,
  input  logic [DM_AW-1:0] load_addr,
  input  logic [31:0]      load_data,
  input  logic [DM_AW-1:0] dbg_addr,
  output logic [31:0]      dbg_data,
  output logic             done,
  output logic [CNT_W-1:0] inst_count,
  output logic [31:0]      pc_out
);
  localparam logic [RIDX-1:0] LINK_IDX = RIDX'(RF_DEPTH - 1);

  run_state_t       state;
  logic [31:0]      pc, npc, pc_plus4;
  logic [CNT_W-1:0] count;
  logic [31:0]      hi, lo;
  logic             running;

  // instruction fields
  logic [5:0]      op, fn;
  logic [RIDX-1:0] rs_idx, rt_idx, rd_idx;
  logic [4:0]      shamt;
  logic [15:0]     imm;
  logic [25:0]     tgt;

  assign op     = imem_data[31:26];
  assign rs_idx = imem_data[25:21];
  assign rt_idx = imem_data[20:16];
  assign rd_idx = imem_data[15:11];
  assign shamt  = imem_data[10:6];
  assign fn     = imem_data[5:0];
  assign imm    = imem_data[15:0];
  assign tgt    = imem_data[25:0];

  assign running   = (state == ST_RUN);
  assign imem_addr = pc[IM_AW+1:2];
  assign pc_plus4  = pc + 32'd4;

  // register file
  logic [31:0]     rs_val, rt_val, wb_val;
  logic [RIDX-1:0] wb_idx;
  logic            wb_en;

  scpu_regfile #(.DEPTH(RF_DEPTH), .SP_IDX(29), .SP_INIT(SP_INIT)) u_rf (
    .clk(clk), .rst(rst),
    .ra_idx(rs_idx), .ra_val(rs_val),
    .rb_idx(rt_idx), .rb_val(rt_val),
    .we(wb_en), .w_idx(wb_idx), .w_val(wb_val)
  );

  // decode and execute
  logic [31:0] ex_res;
  logic [63:0] ex_hilo;
  logic ex_wr, ex_wr_rd, ex_hilo_we, ex_ld, ex_st, ex_jmp, ex_lnk, ex_jreg, ex_br, ex_cond, ex_ill;

  scpu_exec u_ex (
    .op(op), .fn(fn), .shamt(shamt), .imm(imm),
    .a(rs_val), .b(rt_val), .hi(hi), .lo(lo),
    .res(ex_res), .wr_en(ex_wr), .wr_rd(ex_wr_rd),
    .hilo_we(ex_hilo_we), .hilo_new(ex_hilo),
    .ld(ex_ld), .st(ex_st), .jmp(ex_jmp), .lnk(ex_lnk),
    .jreg(ex_jreg), .br(ex_br), .cond(ex_cond), .ill(ex_ill)
  );

  // named events for the assertions
  logic br_taken, store_fire, halt_now;
  assign br_taken   = ex_br & ex_cond;
  assign store_fire = running & ex_st;

  // data memory
  logic [31:0]      mem_addr, dm_rdata, dm_wdata;
  logic [DM_AW-1:0] dm_idx, dm_waddr;
  logic             dm_we;
  logic             unused_addr_bits;

  assign mem_addr         = rs_val + f_sext16(imm);
  assign dm_idx           = mem_addr[DM_AW+1:2];
  assign unused_addr_bits = ^{mem_addr[31:DM_AW+2], mem_addr[1:0]};

  assign dm_we    = store_fire | (load_en & ~running);
  assign dm_waddr = running ? dm_idx : load_addr;
  assign dm_wdata = running ? rt_val : load_data;

  scpu_dmem #(.WORDS(DM_WORDS)) u_dm (
    .clk(clk), .rst(rst),
    .we(dm_we), .waddr(dm_waddr), .wdata(dm_wdata),
    .raddr(dm_idx), .rdata(dm_rdata),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  // write-back
  assign wb_en  = running & (ex_wr | ex_lnk);
  assign wb_idx = ex_lnk ? LINK_IDX : (ex_wr_rd ? rd_idx : rt_idx);
  assign wb_val = ex_lnk ? pc_plus4 : (ex_ld ? dm_rdata : ex_res);

  // PC sequencing
  always_comb begin
    if (ex_ill)        npc = '0;
    else if (ex_jreg)  npc = rs_val;
    else if (ex_jmp)   npc = f_jump_tgt(tgt);
    else if (br_taken) npc = f_branch_tgt(pc, imm);
    else               npc = pc_plus4;
  end
  assign halt_now = running & (npc == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      pc    <= RESET_PC;
      count <= '0;
      hi    <= '0;
      lo    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) state <= ST_RUN;
        ST_RUN: begin
          pc    <= npc;
          count <= count + 1'b1;
          if (ex_hilo_we) {hi, lo} <= ex_hilo;
          if (halt_now) state <= ST_HALT;
        end
        default: ;
      endcase
    end
  end

  assign done       = (state == ST_HALT);
  assign inst_count = count;
  assign pc_out     = pc;

  // R1: the PC and the count hold their reset values until started
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (pc == RESET_PC && count == '0));

  // R12: one count per executed instruction
  a_r12_count_step: assert property (@(posedge clk) disable iff (rst)
    running |=> (count == $past(count) + 1'b1));

  // R11: once halted, nothing moves
  a_r11_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && $stable(count) && pc == '0));

  // R8: a taken branch lands relative to its own address
  a_r8_branch_rel: assert property (@(posedge clk) disable iff (rst)
    (running && br_taken) |=> (pc == $past(pc) + {{14{$past(imm[15])}}, $past(imm), 2'b00}));

  // R10: an undefined encoding ends the run
  a_r10_illegal_halts: assert property (@(posedge clk) disable iff (rst)
    (running && ex_ill) |=> done);

  // R9: register 0 never reads back non-zero
  a_r9_zero_reg: assert property (@(posedge clk) disable iff (rst)
    (rs_idx == '0) |-> (rs_val == '0));

  // R2: decode classes are mutually exclusive
  a_r2_one_class: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ex_ld, ex_st, ex_jmp, ex_jreg, ex_br, ex_ill, ex_hilo_we}));
endmodule

// File: tb/tb_scpu_core.sv
`timescale 1ns/1ps
module tb_scpu_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [5:0]  imem_addr;
  logic [31:0] imem_data;
  logic        load_en = 1'b0;
  logic [5:0]  load_addr = '0;
  logic [31:0] load_data = '0;
  logic [5:0]  dbg_addr = '0;
  logic [31:0] dbg_data;
  logic        done;
  logic [31:0] inst_count;
  logic [31:0] pc_out;

  always #4 clk = ~clk;

  logic [31:0] imem     [64];
  logic [31:0] init_mem [64];
  logic [31:0] m_mem    [64];
  int          m_count;
  int          checks = 0;
  int          errors = 0;

  always_comb imem_data = imem[imem_addr];

  scpu_core dut (
    .clk(clk), .rst(rst), .start(start),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data),
    .done(done), .inst_count(inst_count), .pc_out(pc_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rtype(int fn, int rs, int rt, int rd, int sh);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
  endfunction
  function automatic logic [31:0] itype(int op, int rs, int rt, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] jtype(int op, int t);
    return {op[5:0], t[25:0]};
  endfunction

  task automatic fill_imem();
    for (int i = 0; i < 64; i++) imem[i] = rtype(1, 0, 0, 0, 0);
  endtask

  // instruction-level model of the requirements
  task automatic model_run();
    logic [31:0] r [32];
    logic [31:0] p, ins, nxt, si, zi, ea, mhi, mlo;
    logic [5:0]  o, f;
    logic [4:0]  s, t, d, sh;
    longint      sp;
    longint unsigned up;
    for (int i = 0; i < 32; i++) r[i] = 0;
    r[29] = 32'h7fffeffc;
    for (int i = 0; i < 64; i++) m_mem[i] = init_mem[i];
    p = 32'h00400000; m_count = 0; mhi = 0; mlo = 0;
    while (p != 0 && m_count < 4000) begin
      ins = imem[p[7:2]];
      nxt = p + 4;
      m_count++;
      o = ins[31:26]; s = ins[25:21]; t = ins[20:16]; d = ins[15:11]; sh = ins[10:6]; f = ins[5:0];
      si = {{16{ins[15]}}, ins[15:0]};
      zi = {16'h0, ins[15:0]};
      ea = r[s] + si;
      if (o == 0) begin
        if (f == 33) r[d] = r[s] + r[t];
        else if (f == 35) r[d] = r[s] - r[t];
        else if (f == 36) r[d] = r[s] & r[t];
        else if (f == 37) r[d] = r[s] | r[t];
        else if (f == 38) r[d] = r[s] ^ r[t];
        else if (f == 0)  r[d] = r[t] << sh;
        else if (f == 2)  r[d] = r[t] >> sh;
        else if (f == 4)  r[d] = r[t] << r[s][4:0];
        else if (f == 6)  r[d] = r[t] >> r[s][4:0];
        else if (f == 42) r[d] = ($signed(r[s]) < $signed(r[t])) ? 1 : 0;
        else if (f == 43) r[d] = (r[s] < r[t]) ? 1 : 0;
        else if (f == 16) r[d] = mhi;
        else if (f == 18) r[d] = mlo;
        else if (f == 24) begin
          sp = longint'($signed(r[s])) * longint'($signed(r[t]));
          mhi = sp[63:32]; mlo = sp[31:0];
        end else if (f == 25) begin
          up = longint'({32'h0, r[s]}) * longint'({32'h0, r[t]});
          mhi = up[63:32]; mlo = up[31:0];
        end else if (f == 8) nxt = r[s];
        else nxt = 0;
      end
      else if (o == 2) nxt = {4'h0, ins[25:0], 2'b00};
      else if (o == 3) begin r[31] = nxt; nxt = {4'h0, ins[25:0], 2'b00}; end
      else if (o == 9)  r[t] = r[s] + si;
      else if (o == 10) r[t] = ($signed(r[s]) < $signed(si)) ? 1 : 0;
      else if (o == 11) r[t] = (r[s] < zi) ? 1 : 0;
      else if (o == 12) r[t] = r[s] & zi;
      else if (o == 13) r[t] = r[s] | zi;
      else if (o == 14) r[t] = r[s] ^ zi;
      else if (o == 15) r[t] = {ins[15:0], 16'h0};
      else if (o == 35) r[t] = m_mem[ea[7:2]];
      else if (o == 43) m_mem[ea[7:2]] = r[t];
      else if (o == 4) begin if (r[s] == r[t]) nxt = p + (si << 2); end
      else if (o == 5) begin if (r[s] != r[t]) nxt = p + (si << 2); end
      else if (o == 1) begin if (!r[s][31]) nxt = p + (si << 2); end
      else nxt = 0;
      r[0] = 0;
      p = nxt;
    end
  endtask

  task automatic dut_run(output int cnt, output bit fin);
    rst = 1'b1; start = 1'b0; load_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 64; i++) begin
      load_en = 1'b1; load_addr = i[5:0]; load_data = init_mem[i];
      @(negedge clk);
    end
    load_en = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fin = 1'b0;
    for (int k = 0; k < 5000 && !fin; k++) begin
      if (done) fin = 1'b1;
      else @(negedge clk);
    end
    cnt = int'(inst_count);
  endtask

  task automatic mem_word(input int idx, output logic [31:0] v);
    dbg_addr = idx[5:0];
    #1;
    v = dbg_data;
  endtask

  task automatic compare_all(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 64; i++) begin
      mem_word(i, v);
      chk(tag, v, m_mem[i]);
    end
  endtask

  function automatic logic [31:0] rand_op();
    int sel, rs, rt, rd, sh, im;
    sel = int'($urandom % 21);
    rs = 1 + int'($urandom % 7);
    rt = 1 + int'($urandom % 7);
    rd = int'($urandom % 8);
    sh = int'($urandom % 32);
    im = int'($urandom);
    case (sel)
      0:  return rtype(33, rs, rt, rd, 0);
      1:  return rtype(35, rs, rt, rd, 0);
      2:  return rtype(36, rs, rt, rd, 0);
      3:  return rtype(37, rs, rt, rd, 0);
      4:  return rtype(38, rs, rt, rd, 0);
      5:  return rtype(0, 0, rt, rd, sh);
      6:  return rtype(2, 0, rt, rd, sh);
      7:  return rtype(4, rs, rt, rd, 0);
      8:  return rtype(6, rs, rt, rd, 0);
      9:  return rtype(42, rs, rt, rd, 0);
      10: return rtype(43, rs, rt, rd, 0);
      11: return itype(9, rs, rd, im);
      12: return itype(12, rs, rd, im);
      13: return itype(13, rs, rd, im);
      14: return itype(14, rs, rd, im);
      15: return itype(15, 0, rd, im);
      16: return itype(10, rs, rd, im);
      17: return itype(11, rs, rd, im);
      18: return rtype((im & 1) != 0 ? 25 : 24, rs, rt, 0, 0);
      19: return rtype(16, 0, 0, rd, 0);
      default: return rtype(18, 0, 0, rd, 0);
    endcase
  endfunction

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    bit fin;
    logic [31:0] v;
    logic [31:0] sorted [8];
    void'($urandom(32'h5eed));
    fill_imem();
    for (int i = 0; i < 64; i++) init_mem[i] = 0;

    // reset state
    repeat (3) @(negedge clk);
    chk("R1 pc", pc_out, 32'h00400000);
    chk("R1 done", {31'b0, done}, 32'd0);
    chk("R1 count", inst_count, 32'd0);
    chk("R2 imem_addr", {26'b0, imem_addr}, 32'd0);
    rst = 1'b0;
    load_en = 1'b1; load_addr = 6'd5; load_data = 32'ha5a51234;
    @(negedge clk);
    load_en = 1'b0;
    mem_word(5, v);
    chk("R13 preload", v, 32'ha5a51234);
    repeat (3) @(negedge clk);
    chk("R1 pc idle", pc_out, 32'h00400000);

    // bubble sort with a call/return tail
    fill_imem();
    imem[0]  = itype(9, 0, 1, 7);
    imem[1]  = itype(9, 0, 2, 0);
    imem[2]  = rtype(33, 0, 1, 3, 0);
    imem[3]  = itype(35, 2, 4, 0);
    imem[4]  = itype(35, 2, 5, 4);
    imem[5]  = rtype(42, 5, 4, 6, 0);
    imem[6]  = itype(4, 6, 0, 3);
    imem[7]  = itype(43, 2, 5, 0);
    imem[8]  = itype(43, 2, 4, 4);
    imem[9]  = itype(9, 2, 2, 4);
    imem[10] = itype(9, 3, 3, -1);
    imem[11] = itype(5, 3, 0, -8);
    imem[12] = itype(9, 1, 1, -1);
    imem[13] = itype(5, 1, 0, -12);
    imem[14] = jtype(3, 16);
    imem[15] = rtype(8, 0, 0, 0, 0);
    imem[16] = itype(43, 0, 31, 32);
    imem[17] = itype(43, 0, 29, 36);
    imem[18] = rtype(8, 31, 0, 0, 0);
    for (int i = 0; i < 64; i++) init_mem[i] = 0;
    init_mem[0] = 31;  init_mem[1] = -4; init_mem[2] = 7;  init_mem[3] = 0;
    init_mem[4] = -19; init_mem[5] = 12; init_mem[6] = 5;  init_mem[7] = -1;
    sorted[0] = -19; sorted[1] = -4; sorted[2] = -1; sorted[3] = 0;
    sorted[4] = 5;   sorted[5] = 7;  sorted[6] = 12; sorted[7] = 31;
    model_run();
    dut_run(cnt, fin);
    chk("R11 sort done", {31'b0, fin}, 32'd1);
    chk("R12 sort count", cnt, m_count);
    for (int i = 0; i < 8; i++) begin
      mem_word(i, v);
      chk("R6 R8 sorted word", v, sorted[i]);
    end
    mem_word(8, v);
    chk("R7 link value", v, 32'h0040003c);
    mem_word(9, v);
    chk("R1 stack reg", v, 32'h7fffeffc);
    chk("R11 pc zero", pc_out, 32'd0);
    repeat (5) @(negedge clk);
    chk("R11 done held", {31'b0, done}, 32'd1);
    chk("R11 count frozen", inst_count, m_count);
    compare_all("R6 sort memory");

    // bgez, r0 write, multiply
    fill_imem();
    imem[0]  = itype(9, 0, 1, -5);
    imem[1]  = itype(1, 1, 0, 2);
    imem[2]  = itype(9, 0, 2, 1);
    imem[3]  = itype(1, 0, 7, 2);
    imem[4]  = itype(9, 2, 2, 100);
    imem[5]  = itype(9, 0, 0, 9);
    imem[6]  = itype(43, 0, 0, 0);
    imem[7]  = itype(43, 0, 2, 4);
    imem[8]  = rtype(24, 1, 1, 0, 0);
    imem[9]  = rtype(18, 0, 0, 3, 0);
    imem[10] = rtype(16, 0, 0, 4, 0);
    imem[11] = rtype(25, 1, 1, 0, 0);
    imem[12] = rtype(16, 0, 0, 5, 0);
    imem[13] = itype(43, 0, 3, 8);
    imem[14] = itype(43, 0, 4, 12);
    imem[15] = itype(43, 0, 5, 16);
    imem[16] = 32'hfc000000;
    for (int i = 0; i < 64; i++) init_mem[i] = 32'h11111111;
    model_run();
    dut_run(cnt, fin);
    chk("R12 directed count", cnt, 32'd16);
    mem_word(0, v); chk("R9 r0 stays zero", v, 32'd0);
    mem_word(1, v); chk("R8 bgez paths", v, 32'd1);
    mem_word(2, v); chk("R5 signed lo", v, 32'd25);
    mem_word(3, v); chk("R5 signed hi", v, 32'd0);
    mem_word(4, v); chk("R5 unsigned hi", v, 32'hfffffff6);
    chk("R10 bad opcode halts", {31'b0, done}, 32'd1);
    compare_all("R5 R8 directed memory");

    // undefined function code as the first instruction
    fill_imem();
    imem[0] = rtype(1, 0, 0, 0, 0);
    dut_run(cnt, fin);
    chk("R10 bad funct count", cnt, 32'd1);
    chk("R10 bad funct pc", pc_out, 32'd0);

    // random register/immediate programs
    for (int n = 0; n < 20; n++) begin
      fill_imem();
      for (int k = 0; k < 30; k++) imem[k] = rand_op();
      for (int j = 1; j <= 7; j++) imem[29 + j] = itype(43, 0, j, (15 + j) * 4);
      imem[37] = rtype(8, 0, 0, 0, 0);
      for (int i = 0; i < 64; i++) init_mem[i] = $urandom;
      model_run();
      dut_run(cnt, fin);
      chk("R12 random count", cnt, m_count);
      compare_all("R3 R4 R5 R9 random memory");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule